// File: doc/BRIEF.md
# Streaming Pixel Point-Operation Unit

This unit sits in a raster pixel stream ahead of a neighbourhood filter and applies one point operation to each pixel as it passes, at a rate of one pixel per clock. The available operations are:

- a binary threshold against a programmable level;
- bitwise inversion;
- a left or right shift by a programmable amount;
- saturating addition or subtraction of a co-registered pixel taken from a second frame input.

An enable input switches the unit into or out of the datapath. When the unit is switched out, pixels pass through unchanged with exactly the same latency, so downstream timing does not change when the mode changes.

All control inputs are sampled together with the pixel they accompany. The operation, threshold, shift amount and enable can therefore change from one pixel to the next with no dead cycles. The pixel width is a parameter, typically 8 or 12 bits.

Top module: `pix_point_alu`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid` is 0 and `out_pix` is 0.
- R2: Every pixel accepted with `in_valid` high appears on `out_pix` with `out_valid` high exactly 2 clock cycles later. Back-to-back input pixels give back-to-back outputs in the same order.
- R3: With `alu_en` = 0, the output pixel equals the input pixel, whatever `op_sel` selects.
- R4: With `alu_en` = 1 and `op_sel` = 0 (threshold), the output is all ones when `in_pix` >= `thresh` and 0 otherwise.
- R5: With `op_sel` = 1 (invert), the output is the bitwise complement of `in_pix`.
- R6: With `op_sel` = 2 (shift), the output is `in_pix` shifted by `shamt` bits with zero fill. The shift is left when `sh_left` = 1 and right when `sh_left` = 0. A shift of W or more bits gives 0.
- R7: With `op_sel` = 3 (two-frame add), the output is `in_pix` + `in_pix_b`, clamped to all ones on overflow.
- R8: With `op_sel` = 4 (two-frame subtract), the output is `in_pix` - `in_pix_b`, clamped to 0 when the result would be negative.
- R9: Codes 5 to 7 of `op_sel` pass the pixel through unchanged.
- R10: The control inputs are sampled per pixel, so a change of mode or operation applies from the very pixel that accompanies it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel qualifier |
| in_pix | input | W | Primary stream pixel |
| in_pix_b | input | W | Co-registered pixel from the second frame |
| alu_en | input | 1 | 1 = apply the operation, 0 = pass through |
| op_sel | input | 3 | Operation code (see R4 to R9) |
| thresh | input | W | Threshold level |
| shamt | input | 4 | Shift amount |
| sh_left | input | 1 | Shift direction, 1 = left |
| out_valid | output | 1 | Output pixel qualifier |
| out_pix | output | W | Result pixel |

## Verification
Every result, in both modes and for every operation, is due 2 clocks after the edge that accepts its input pixel. The driver records that due cycle next to the expected value when it queues an item. The monitor samples on the falling edge. It flags a result that arrives early or late, as well as one that never arrives. Streams that change mode or operation pixel by pixel show that the fixed latency also holds across switches.

// File: rtl/pix_point_alu.sv
module pix_point_alu #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_pix,
  input  logic [W-1:0] in_pix_b,
  input  logic         alu_en,
  input  logic [2:0]   op_sel,
  input  logic [W-1:0] thresh,
  input  logic [3:0]   shamt,
  input  logic         sh_left,
  output logic         out_valid,
  output logic [W-1:0] out_pix
);
  localparam logic [2:0] OP_THR = 3'd0;
  localparam logic [2:0] OP_INV = 3'd1;
  localparam logic [2:0] OP_SHF = 3'd2;
  localparam logic [2:0] OP_ADD = 3'd3;
  localparam logic [2:0] OP_SUB = 3'd4;
  localparam logic [W-1:0] ONES = {W{1'b1}};

  logic         v1, en1, left1;
  logic [2:0]   op1;
  logic [W-1:0] a1, b1, th1;
  logic [3:0]   sh1;
  logic [W:0]   sum, dif;
  logic [W-1:0] res;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1 <= 1'b0; en1 <= 1'b0; left1 <= 1'b0; op1 <= '0;
      a1 <= '0; b1 <= '0; th1 <= '0; sh1 <= '0;
    end else begin
      v1 <= in_valid;
      if (in_valid) begin
        en1 <= alu_en; op1 <= op_sel; a1 <= in_pix; b1 <= in_pix_b;
        th1 <= thresh; sh1 <= shamt; left1 <= sh_left;
      end
    end
  end

  assign sum = {1'b0, a1} + {1'b0, b1};
  assign dif = {1'b0, a1} - {1'b0, b1};

  always_comb begin
    res = a1;
    if (en1) begin
      case (op1)
        OP_THR:  res = (a1 >= th1) ? ONES : '0;
        OP_INV:  res = ~a1;
        OP_SHF:  res = left1 ? (a1 << sh1) : (a1 >> sh1);
        OP_ADD:  res = sum[W] ? ONES : sum[W-1:0];
        OP_SUB:  res = dif[W] ? '0 : dif[W-1:0];
        default: res = a1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
    end else begin
      out_valid <= v1;
      if (v1) out_pix <= res;
    end
  end

  AST_VALID_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(v1)); // R2
  AST_BYPASS_SAME: assert property (@(posedge clk) disable iff (!rst_n)
    (v1 && !en1) |=> (out_pix == $past(a1))); // R3
  AST_THRESH_BINARY: assert property (@(posedge clk) disable iff (!rst_n)
    (v1 && en1 && op1 == OP_THR) |=> (out_pix == '0 || out_pix == ONES)); // R4
  AST_ADD_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (v1 && en1 && op1 == OP_ADD) |=> (out_pix >= $past(a1))); // R7
  AST_SUB_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (v1 && en1 && op1 == OP_SUB) |=> (out_pix <= $past(a1))); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !v1 |=> $stable(out_pix)); // R2
endmodule

// File: tb/pix_point_alu_tb.sv
module pix_point_alu_tb;
  localparam int W = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, alu_en = 1'b0, sh_left = 1'b0;
  logic [W-1:0] in_pix = '0, in_pix_b = '0, thresh = '0;
  logic [2:0] op_sel = '0;
  logic [3:0] shamt = '0;
  logic out_valid;
  logic [W-1:0] out_pix;

  int cyc = 0, checks = 0, errors = 0;
  logic [W-1:0] q_pix[$];
  int q_due[$];
  string q_req[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pix_point_alu #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix),
    .in_pix_b(in_pix_b), .alu_en(alu_en), .op_sel(op_sel), .thresh(thresh),
    .shamt(shamt), .sh_left(sh_left), .out_valid(out_valid), .out_pix(out_pix));

  function automatic logic [W-1:0] model(input logic [W-1:0] a, b, th,
      input logic en, input logic [2:0] op, input int sh, input logic lft);
    int s;
    if (!en) return a;
    case (op)
      3'd0: return (a >= th) ? {W{1'b1}} : '0;
      3'd1: return ~a;
      3'd2: begin
        if (sh >= W) return '0;
        return lft ? W'(int'(a) << sh) : W'(int'(a) >> sh);
      end
      3'd3: begin s = int'(a) + int'(b); return (s > (1 << W) - 1) ? {W{1'b1}} : W'(s); end
      3'd4: begin s = int'(a) - int'(b); return (s < 0) ? '0 : W'(s); end
      default: return a;
    endcase
  endfunction

  task automatic send(input logic [W-1:0] a, b, th, input logic en,
      input logic [2:0] op, input int sh, input logic lft, input string req);
    @(negedge clk);
    in_valid = 1'b1; in_pix = a; in_pix_b = b; thresh = th; alu_en = en;
    op_sel = op; shamt = 4'(sh); sh_left = lft;
    q_pix.push_back(model(a, b, th, en, op, sh, lft));
    q_due.push_back(cyc + 2);
    q_req.push_back(req);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; in_pix = 8'hA5; op_sel = 3'd1; alu_en = 1'b1;
    end
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk); #1;
      if (rst_n) begin
        if (out_valid) begin
          checks++;
          if (q_pix.size() == 0) begin
            errors++; $display("FAIL R2: unexpected output %h, expected none", out_pix);
          end else begin
            if (out_pix !== q_pix[0] || cyc != q_due[0]) begin
              errors++;
              $display("FAIL %s: pix %h at cycle %0d, expected %h at cycle %0d",
                       q_req[0], out_pix, cyc, q_pix[0], q_due[0]);
            end
            void'(q_pix.pop_front()); void'(q_due.pop_front()); void'(q_req.pop_front());
          end
        end else if (q_due.size() != 0 && q_due[0] <= cyc) begin
          checks++; errors++;
          $display("FAIL R2: no output at cycle %0d, expected %h at cycle %0d",
                   cyc, q_pix[0], q_due[0]);
          void'(q_pix.pop_front()); void'(q_due.pop_front()); void'(q_req.pop_front());
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R2: watchdog expired, got hang, expected completion");
    summary();
  end

  initial begin
    in_valid = 1'b1; in_pix = 8'h3C;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_pix !== '0) begin
      errors++; $display("FAIL R1: during reset valid %b pix %h, expected 0 00", out_valid, out_pix);
    end
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk); #1;
    checks++;
    if (out_valid !== 1'b0 || out_pix !== '0) begin
      errors++; $display("FAIL R1: after reset valid %b pix %h, expected 0 00", out_valid, out_pix);
    end
    // R3 bypass with various op codes
    send(8'h12, 8'hFF, 8'h80, 1'b0, 3'd0, 0, 0, "R3");
    send(8'hF0, 8'hFF, 8'h00, 1'b0, 3'd1, 3, 1, "R3");
    send(8'h7E, 8'h90, 8'h00, 1'b0, 3'd3, 0, 0, "R3");
    idle(2);
    // R4 threshold boundaries
    send(8'h80, 8'h00, 8'h80, 1'b1, 3'd0, 0, 0, "R4");
    send(8'h7F, 8'h00, 8'h80, 1'b1, 3'd0, 0, 0, "R4");
    send(8'h00, 8'h00, 8'h00, 1'b1, 3'd0, 0, 0, "R4");
    send(8'hFE, 8'h00, 8'hFF, 1'b1, 3'd0, 0, 0, "R4");
    // R5 invert
    send(8'h5A, 8'h00, 8'h00, 1'b1, 3'd1, 0, 0, "R5");
    send(8'h00, 8'h00, 8'h00, 1'b1, 3'd1, 0, 0, "R5");
    // R6 shifts
    send(8'hB3, 8'h00, 8'h00, 1'b1, 3'd2, 3, 0, "R6");
    send(8'hB3, 8'h00, 8'h00, 1'b1, 3'd2, 3, 1, "R6");
    send(8'hB3, 8'h00, 8'h00, 1'b1, 3'd2, 0, 1, "R6");
    send(8'hFF, 8'h00, 8'h00, 1'b1, 3'd2, 8, 1, "R6");
    send(8'hFF, 8'h00, 8'h00, 1'b1, 3'd2, 15, 0, "R6");
    idle(1);
    // R7 saturating add
    send(8'h40, 8'h30, 8'h00, 1'b1, 3'd3, 0, 0, "R7");
    send(8'hF0, 8'h0F, 8'h00, 1'b1, 3'd3, 0, 0, "R7");
    send(8'hF0, 8'h10, 8'h00, 1'b1, 3'd3, 0, 0, "R7");
    send(8'hC8, 8'hC8, 8'h00, 1'b1, 3'd3, 0, 0, "R7");
    // R8 saturating subtract
    send(8'h40, 8'h30, 8'h00, 1'b1, 3'd4, 0, 0, "R8");
    send(8'h30, 8'h30, 8'h00, 1'b1, 3'd4, 0, 0, "R8");
    send(8'h30, 8'h31, 8'h00, 1'b1, 3'd4, 0, 0, "R8");
    // R9 reserved codes
    send(8'h6D, 8'h11, 8'h00, 1'b1, 3'd5, 2, 1, "R9");
    send(8'h6D, 8'h11, 8'h00, 1'b1, 3'd6, 2, 0, "R9");
    send(8'h6D, 8'h11, 8'h00, 1'b1, 3'd7, 0, 0, "R9");
    idle(3);
    // R10 per-pixel switching, back to back
    for (int i = 0; i < 24; i++) begin
      send(W'(i * 37 + 5), W'(i * 53 + 9), W'(i * 11), i[0], 3'(i % 5), i % 10, i[1], "R10");
    end
    idle(6);
    checks++;
    if (q_pix.size() != 0) begin
      errors++; $display("FAIL R2: %0d outputs missing, expected 0", q_pix.size());
    end
    summary();
  end
endmodule